// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block is the receive half of a DMA-style network port. A small internal word RAM holds both a ring of descriptors and the buffers they point to. Each descriptor is four consecutive words. The word at offset 0 carries control and status, with bit 31 as the hardware-ownership flag. Offset 1 is a shared size word: capacity in bits 31:16, received length in bits 15:0. Offset 2 is the buffer word address and offset 3 the word address of the next descriptor. Software fills the ring through the memory port, points the engine at the first descriptor and issues a start command. After that the engine places each incoming byte stream into the current descriptor's buffer.

When a frame ends, the engine writes the length into the size word. In the following cycle it hands the descriptor back to software by clearing the ownership flag, and then moves to the descriptor named in the link word. If a frame starts while the current descriptor still belongs to software, the engine drops the frame, raises a no-resource flag and stalls. It stays stalled until the next start command.

Top module: `rx_ring_dma`

## Requirements
- R1: After reset, cur_ptr is 0, and running, no_res and busy are all 0.
- R2: A command write (reg_we=1, reg_sel=1) of exactly 0x80008000 clears running. Any other command value with bit 7 set sets running and clears no_res. Any other value has no effect.
- R3: Byte i of an accepted frame is stored in the low 8 bits of memory word (buffer word + i), with the upper 24 bits zero. The buffer word is the low address bits of descriptor word 2.
- R4: When a frame completes, descriptor word 1 becomes {capacity, length}. The capacity in bits 31:16 is kept, and bits 15:0 hold the number of stored bytes.
- R5: One cycle after the length write, descriptor word 0 is rewritten with bit 31 cleared, bit 0 set to the overrun result, and bits 30:1 unchanged.
- R6: Bytes beyond the capacity are not written to memory. The stored length equals the capacity, and bit 0 of descriptor word 0 is 1 only when the frame was longer than the capacity.
- R7: Once a frame completes, cur_ptr takes the low address bits of descriptor word 3, so a ring whose last link points at the first descriptor wraps.
- R8: A frame that starts while running is 1 and bit 31 of the current descriptor is 0 is dropped, with no memory change. It sets no_res, clears running and leaves cur_ptr unchanged.
- R9: While running is 0, frames are dropped without any memory change and without altering no_res.
- R10: A frame start is judged on the value running had before a command written in the same cycle.
- R11: A pointer write (reg_we=1, reg_sel=0) loads cur_ptr with the low address bits of reg_wdata.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Host register write strobe |
| reg_sel | input | 1 | 0 selects the descriptor pointer, 1 selects the command |
| reg_wdata | input | 32 | Host register write data |
| cur_ptr | output | AW | Current descriptor word address |
| running | output | 1 | Engine accepts new frames |
| no_res | output | 1 | A frame hit a software-owned descriptor |
| busy | output | 1 | A frame or its write-back is in progress |
| rx_valid | input | 1 | Receive byte valid |
| rx_sof | input | 1 | First byte of a frame |
| rx_eof | input | 1 | Last byte of a frame |
| rx_data | input | 8 | Receive byte |
| mem_we | input | 1 | Host memory write (ignored while the engine writes) |
| mem_addr | input | AW | Host memory word address |
| mem_wdata | input | 32 | Host memory write data |
| mem_rdata | output | 32 | Host memory read data (combinational) |

## Verification
A start command and the first byte of a frame can land in the same cycle. The bench provokes this by stopping the engine and then driving the start write together with a frame's first byte. The frame must be dropped because it saw the old stopped state: its buffer words keep their sentinel fill, the descriptor words stay as written, and cur_ptr does not move, while running reads 1 afterwards. Frame lengths are swept across and past the capacity around a three-descriptor ring, and each stored byte, length, status and pointer is predicted arithmetically.

// File: rtl/rx_ring_dma.sv
module rx_ring_dma #(
  parameter int WORDS = 256,
  localparam int AW = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic          reg_sel,
  input  logic [31:0]   reg_wdata,
  output logic [AW-1:0] cur_ptr,
  output logic          running,
  output logic          no_res,
  output logic          busy,
  input  logic          rx_valid,
  input  logic          rx_sof,
  input  logic          rx_eof,
  input  logic [7:0]    rx_data,
  input  logic          mem_we,
  input  logic [AW-1:0] mem_addr,
  input  logic [31:0]   mem_wdata,
  output logic [31:0]   mem_rdata
);
  localparam logic [31:0] STOP_CMD = 32'h8000_8000;
  typedef enum logic [1:0] {S_IDLE, S_DATA, S_CNT, S_OWN} st_t;

  st_t           state;
  logic [31:0]   mem [WORDS];
  logic [AW-1:0] cur, dbase, bufq;
  logic [15:0]   capq, cnt;
  logic          ovr, run, nores;

  wire idle    = (state == S_IDLE);
  wire sof_in  = idle && rx_valid && rx_sof && run;
  wire own_now = mem[cur][31];
  wire sof_ok  = sof_in && own_now;
  wire sof_bad = sof_in && !own_now;
  wire take    = sof_ok || (state == S_DATA && rx_valid);
  wire [AW-1:0] buf_b = idle ? mem[cur + AW'(2)][AW-1:0] : bufq;
  wire [15:0]   cap_b = idle ? mem[cur + AW'(1)][31:16] : capq;
  wire [15:0]   cnt_b = idle ? 16'd0 : cnt;
  wire          fits  = cnt_b < cap_b;
  wire [AW-1:0] nxt   = mem[dbase + AW'(3)][AW-1:0];
  wire          ptr_we = reg_we && !reg_sel;
  wire          cmd_we = reg_we && reg_sel;

  logic          e_we;
  logic [AW-1:0] e_wa;
  logic [31:0]   e_wd;

  always_comb begin
    e_we = mem_we;
    e_wa = mem_addr;
    e_wd = mem_wdata;
    if (take && fits) begin
      e_we = 1'b1;
      e_wa = buf_b + cnt_b[AW-1:0];
      e_wd = {24'd0, rx_data};
    end else if (state == S_CNT) begin
      e_we = 1'b1;
      e_wa = dbase + AW'(1);
      e_wd = {capq, cnt};
    end else if (state == S_OWN) begin
      e_we = 1'b1;
      e_wa = dbase;
      e_wd = {1'b0, mem[dbase][30:1], ovr};
    end
  end

  always_ff @(posedge clk) if (e_we) mem[e_wa] <= e_wd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      cur   <= '0;
      dbase <= '0;
      bufq  <= '0;
      capq  <= '0;
      cnt   <= '0;
      ovr   <= 1'b0;
      run   <= 1'b0;
      nores <= 1'b0;
    end else begin
      if (sof_bad) begin
        run   <= 1'b0;
        nores <= 1'b1;
      end
      if (cmd_we) begin
        if (reg_wdata == STOP_CMD) run <= 1'b0;
        else if (reg_wdata[7]) begin
          run   <= 1'b1;
          nores <= 1'b0;
        end
      end
      if (take) begin
        if (idle) begin
          dbase <= cur;
          bufq  <= buf_b;
          capq  <= cap_b;
        end
        cnt <= fits ? cnt_b + 16'd1 : cnt_b;
        ovr <= (idle ? 1'b0 : ovr) | !fits;
        state <= rx_eof ? S_CNT : S_DATA;
      end else if (state == S_CNT) begin
        state <= S_OWN;
      end else if (state == S_OWN) begin
        state <= S_IDLE;
      end
      if (ptr_we) cur <= reg_wdata[AW-1:0];
      else if (state == S_OWN) cur <= nxt;
    end
  end

  assign cur_ptr   = cur;
  assign running   = run;
  assign no_res    = nores;
  assign busy      = !idle;
  assign mem_rdata = mem[mem_addr];
endmodule

module rx_ring_dma_chk #(parameter int AW = 8) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    st,
  input logic [15:0]   cnt,
  input logic [15:0]   cap,
  input logic          run,
  input logic          nores,
  input logic [AW-1:0] cur,
  input logic [AW-1:0] nxt,
  input logic          ptr_we
);
  assert_count_in_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st != 2'd0) |-> (cnt <= cap));
  assert_len_then_owner_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd2) |=> (st == 2'd3));
  assert_owner_after_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd3) |-> ($past(st) == 2'd2));
  assert_stall_stops_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nores) |-> !run);
  assert_follow_link_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd3 && !ptr_we) |=> (cur == $past(nxt)));
  assert_stopped_stays_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd0 && !run) |=> (st == 2'd0));
endmodule

bind rx_ring_dma rx_ring_dma_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .st(state), .cnt(cnt), .cap(capq), .run(run),
  .nores(nores), .cur(cur), .nxt(nxt), .ptr_we(ptr_we)
);

// File: tb/tb_rx_ring_dma.sv
module tb_rx_ring_dma;
  localparam int AW = 8;
  localparam int CAP = 5;
  localparam logic [31:0] CMD0 = 32'h0000_0A50;
  localparam logic [31:0] SENT = 32'hEEEE_EEEE;

  logic clk = 0, rst_n = 0;
  logic reg_we = 0, reg_sel = 0;
  logic [31:0] reg_wdata = 0;
  logic [AW-1:0] cur_ptr;
  logic running, no_res, busy;
  logic rx_valid = 0, rx_sof = 0, rx_eof = 0;
  logic [7:0] rx_data = 0;
  logic mem_we = 0;
  logic [AW-1:0] mem_addr = 0;
  logic [31:0] mem_wdata = 0, mem_rdata;
  int checks = 0, failures = 0;

  always #5 clk = ~clk;

  rx_ring_dma dut (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic memw(input int a, input logic [31:0] d);
    @(negedge clk); mem_we = 1; mem_addr = AW'(a); mem_wdata = d;
    @(negedge clk); mem_we = 0;
  endtask

  task automatic memr(input int a, output logic [31:0] d);
    mem_addr = AW'(a); #1; d = mem_rdata;
  endtask

  task automatic regw(input bit sel, input logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_sel = sel; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic arm(input int d, input int bufw, input int nx, input bit own);
    memw(d, own ? (CMD0 | 32'h8000_0000) : CMD0);
    memw(d + 1, CAP << 16);
    memw(d + 2, bufw);
    memw(d + 3, nx);
    for (int i = 0; i < 8; i++) memw(bufw + i, SENT);
  endtask

  task automatic send(input int len, input int seed, input bit with_start);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      reg_we = 0;
      rx_valid = 1; rx_sof = (i == 0); rx_eof = (i == len - 1);
      rx_data = 8'(seed * 16 + i + 1);
      if (i == 0 && with_start) begin
        reg_we = 1; reg_sel = 1; reg_wdata = 32'h80;
      end
    end
    @(negedge clk);
    reg_we = 0; rx_valid = 0; rx_sof = 0; rx_eof = 0;
    repeat (4) @(negedge clk);
  endtask

  task automatic check_untouched(input int d, input int bufw, input logic [31:0] cmd, input string req);
    logic [31:0] v;
    memr(d, v);     chk(v == cmd, req, v, cmd);
    memr(d + 1, v); chk(v == (CAP << 16), req, v, CAP << 16);
    for (int i = 0; i < 8; i++) begin
      memr(bufw + i, v); chk(v == SENT, req, v, SENT);
    end
  endtask

  function automatic int nxt_of(input int d);
    return (d == 8) ? 0 : d + 4;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%h expected=%h", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int d, bufw, stored, exp_cur;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(cur_ptr == 0, "R1", cur_ptr, 0);
    chk(running == 0, "R1", running, 0);
    chk(no_res == 0, "R1", no_res, 0);
    chk(busy == 0, "R1", busy, 0);

    regw(0, 0);
    regw(1, 32'h80);
    chk(running == 1, "R2", running, 1);
    exp_cur = 0;

    // R3 R4 R5 R6 R7 sweep over lengths and ring positions
    for (int f = 0; f < 12; f++) begin
      int len;
      len = f % 8 + 1;
      d = exp_cur;
      bufw = 64 + d * 4;
      arm(d, bufw, nxt_of(d), 1);
      send(len, f, 0);
      stored = (len < CAP) ? len : CAP;
      for (int i = 0; i < 8; i++) begin
        logic [31:0] e;
        e = (i < stored) ? {24'd0, 8'(f * 16 + i + 1)} : SENT;
        memr(bufw + i, v);
        chk(v == e, (i < stored) ? "R3" : "R6", v, e);
      end
      memr(d + 1, v);
      chk(v == ((CAP << 16) | stored), "R4", v, (CAP << 16) | stored);
      memr(d, v);
      chk(v == (CMD0 | 32'(len > CAP)), "R5", v, CMD0 | 32'(len > CAP));
      exp_cur = nxt_of(d);
      chk(cur_ptr == AW'(exp_cur), "R7", cur_ptr, exp_cur);
      chk(busy == 0, "R5", busy, 0);
    end

    // R8 software-owned descriptor stalls
    d = exp_cur; bufw = 64 + d * 4;
    arm(d, bufw, nxt_of(d), 0);
    send(3, 1, 0);
    chk(no_res == 1, "R8", no_res, 1);
    chk(running == 0, "R8", running, 0);
    chk(cur_ptr == AW'(d), "R8", cur_ptr, d);
    check_untouched(d, bufw, CMD0, "R8");
    send(2, 2, 0);
    check_untouched(d, bufw, CMD0, "R9");
    chk(no_res == 1, "R9", no_res, 1);

    // R9 restart re-arms
    regw(1, 32'h0000_0081);
    chk(running == 1, "R9", running, 1);
    chk(no_res == 0, "R9", no_res, 0);
    memw(d, CMD0 | 32'h8000_0000);
    send(4, 3, 0);
    memr(d + 1, v);
    chk(v == ((CAP << 16) | 4), "R4", v, (CAP << 16) | 4);
    exp_cur = nxt_of(d);
    chk(cur_ptr == AW'(exp_cur), "R7", cur_ptr, exp_cur);

    // R2 stop and no-op commands
    regw(1, 32'h8000_8000);
    chk(running == 0, "R2", running, 0);
    regw(1, 32'h0000_0001);
    chk(running == 0, "R2", running, 0);
    d = exp_cur; bufw = 64 + d * 4;
    arm(d, bufw, nxt_of(d), 1);
    send(3, 4, 0);
    check_untouched(d, bufw, CMD0 | 32'h8000_0000, "R9");
    chk(no_res == 0, "R9", no_res, 0);

    // R10 start in the same cycle as a frame start
    send(3, 5, 1);
    check_untouched(d, bufw, CMD0 | 32'h8000_0000, "R10");
    chk(running == 1, "R10", running, 1);
    chk(cur_ptr == AW'(d), "R10", cur_ptr, d);

    // R11 pointer load
    regw(0, 32'hFFFF_FF08);
    chk(cur_ptr == 8'd8, "R11", cur_ptr, 8);
    arm(8, 96, 0, 1);
    send(2, 6, 0);
    memr(9, v);
    chk(v == ((CAP << 16) | 2), "R11", v, (CAP << 16) | 2);
    memr(96, v);
    chk(v == 32'(8'(6 * 16 + 1)), "R3", v, 8'(6 * 16 + 1));
    chk(cur_ptr == 0, "R7", cur_ptr, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule